// File: doc/BRIEF.md
# Dual-Pick Age-Ordered Issue Select

This block picks which integer issue-queue entries leave the queue this cycle. The queue has 20 entries and feeds four execution subclusters, arranged as an upper pair and a lower pair. At an earlier stage each entry is tied to one half. Each entry then raises a request line for every subcluster in that half which can run it and whose operands are ready. Which subcluster of the half it issues to is settled here, in the issue cycle.

Two arbiters work side by side, one for each half. Each arbiter fills at most two slots: slot 0 for subcluster 0 and slot 1 for subcluster 1 of its half. Age decides every contest. The queue keeps itself compacted, so a lower index always means an older instruction. Slot 0 goes to the oldest eligible requester for slot 0. Slot 1 goes to the oldest eligible requester for slot 1 that did not already win slot 0. Because of this, an entry that can use either subcluster takes whichever slot is left open. Grants come straight from the current requests, with no state in between. At most four entries issue per cycle. `clk_i` and `rst_ni` only time the embedded checks.

Top module: `issue_select`

## Requirements
- R1: Each of the four grant vectors is one-hot or all-zero in every cycle.
- R2: A grant bit is set only for an entry that drives the matching request line and is assigned to that half (`half_i` bit 1 = upper, 0 = lower).
- R3: A request on an upper line from a lower entry, or on a lower line from an upper entry, is ignored and produces no grant.
- R4: Slot 0 of each half is granted to the lowest-index eligible entry requesting that slot.
- R5: Slot 1 of each half is granted to the lowest-index eligible entry requesting that slot, leaving out the entry that won slot 0 of the same half.
- R6: No entry is granted both slots of its half in the same cycle.
- R7: If a slot has at least one eligible candidate (for slot 1, other than the slot 0 winner), that slot is granted.
- R8: The two halves arbitrate independently, so up to four grants are issued per cycle.
- R9: Grants are a pure function of the present inputs. With no requests, every grant is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that samples the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset for the checks |
| half_i | input | 20 | Half assignment per entry, 1 = upper, 0 = lower |
| req_u0_i | input | 20 | Requests for upper subcluster 0 |
| req_u1_i | input | 20 | Requests for upper subcluster 1 |
| req_l0_i | input | 20 | Requests for lower subcluster 0 |
| req_l1_i | input | 20 | Requests for lower subcluster 1 |
| gnt_u0_o | output | 20 | One-hot grant, upper subcluster 0 |
| gnt_u1_o | output | 20 | One-hot grant, upper subcluster 1 |
| gnt_l0_o | output | 20 | One-hot grant, lower subcluster 0 |
| gnt_l1_o | output | 20 | One-hot grant, lower subcluster 1 |

## Verification
The two picks of one half fall in the same cycle, and the slot 1 choice depends on the slot 0 winner. The bench sweeps every combination of half assignment and both request lines over the three oldest entries. This covers the case where one entry requests both slots while an older or younger entry requests only one. Pseudo-random fills of all 20 entries follow. Each vector's four grants are compared with a model written from the age and exclusion rules, and the bench also checks that the vector is one-hot, that the grants do not overlap and that no grant goes to a wrong-half entry.

// File: rtl/issue_select_pkg.sv
package issue_select_pkg;
  typedef enum logic {
    HALF_LOWER = 1'b0,
    HALF_UPPER = 1'b1
  } half_e;

  localparam int unsigned NUM_HALVES = 2;
endpackage

// File: rtl/age_pick.sv
module age_pick #(
  parameter int unsigned N = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] excl_i,
  output logic [N-1:0] gnt_o
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] cand;
  logic         found;

  assign cand = req_i & ~excl_i;

  // lowest index = oldest
  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  p_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_grant_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~cand) == '0);
  p_oldest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |-> (((gnt_o - ONE) & cand) == '0));
  p_work_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand != '0) |-> (gnt_o != '0));
endmodule

// File: rtl/half_arb.sv
module half_arb #(
  parameter int unsigned N = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req0_i,
  input  logic [N-1:0] req1_i,
  output logic [N-1:0] gnt0_o,
  output logic [N-1:0] gnt1_o
);
  age_pick #(.N(N)) u_slot0 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req0_i),
    .excl_i({N{1'b0}}),
    .gnt_o (gnt0_o)
  );

  // slot 1 skips the slot 0 winner
  age_pick #(.N(N)) u_slot1 (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req1_i),
    .excl_i(gnt0_o),
    .gnt_o (gnt1_o)
  );

  p_no_dual_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt0_o & gnt1_o) == '0);
  p_slot1_flex_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req1_i & ~gnt0_o) != '0) |-> (gnt1_o != '0));
endmodule

// File: rtl/issue_select.sv
module issue_select
  import issue_select_pkg::*;
#(
  parameter int unsigned N = 20
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] half_i,
  input  logic [N-1:0] req_u0_i,
  input  logic [N-1:0] req_u1_i,
  input  logic [N-1:0] req_l0_i,
  input  logic [N-1:0] req_l1_i,
  output logic [N-1:0] gnt_u0_o,
  output logic [N-1:0] gnt_u1_o,
  output logic [N-1:0] gnt_l0_o,
  output logic [N-1:0] gnt_l1_o
);
  logic [N-1:0] req0 [NUM_HALVES];
  logic [N-1:0] req1 [NUM_HALVES];
  logic [N-1:0] gnt0 [NUM_HALVES];
  logic [N-1:0] gnt1 [NUM_HALVES];

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [N-1:0] own;
    if (h == int'(HALF_UPPER)) begin : g_up
      assign own     = half_i;
      assign req0[h] = req_u0_i & own;
      assign req1[h] = req_u1_i & own;
    end else begin : g_lo
      assign own     = ~half_i;
      assign req0[h] = req_l0_i & own;
      assign req1[h] = req_l1_i & own;
    end

    half_arb #(.N(N)) u_arb (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .req0_i(req0[h]),
      .req1_i(req1[h]),
      .gnt0_o(gnt0[h]),
      .gnt1_o(gnt1[h])
    );
  end

  assign gnt_u0_o = gnt0[int'(HALF_UPPER)];
  assign gnt_u1_o = gnt1[int'(HALF_UPPER)];
  assign gnt_l0_o = gnt0[int'(HALF_LOWER)];
  assign gnt_l1_o = gnt1[int'(HALF_LOWER)];

  p_half_upper_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_u0_o | gnt_u1_o) & ~half_i) == '0);
  p_half_lower_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_l0_o | gnt_l1_o) & half_i) == '0);
  p_max_four_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({gnt_u0_o, gnt_u1_o, gnt_l0_o, gnt_l1_o}) <= 4);
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({req_u0_i, req_u1_i, req_l0_i, req_l1_i} == '0) |->
    ({gnt_u0_o, gnt_u1_o, gnt_l0_o, gnt_l1_o} == '0));
endmodule

// File: tb/tb_issue_select.sv
module tb_issue_select;
  localparam int N = 20;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] half_i = '0;
  logic [N-1:0] req_u0_i = '0, req_u1_i = '0, req_l0_i = '0, req_l1_i = '0;
  logic [N-1:0] gnt_u0_o, gnt_u1_o, gnt_l0_o, gnt_l1_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] rng = 32'h1bad_5eed;

  issue_select #(.N(N)) dut (.*);

  always #2 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog R9: actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [N-1:0] oldest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return (N'(1) << i);
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] hf, input logic [N-1:0] u0, input logic [N-1:0] u1,
                       input logic [N-1:0] l0, input logic [N-1:0] l1);
    logic [N-1:0] e_u0, e_u1, e_l0, e_l1;
    @(negedge clk_i);
    half_i = hf; req_u0_i = u0; req_u1_i = u1; req_l0_i = l0; req_l1_i = l1;
    #1;
    e_u0 = oldest(u0 & hf);
    e_u1 = oldest(u1 & hf & ~e_u0);
    e_l0 = oldest(l0 & ~hf);
    e_l1 = oldest(l1 & ~hf & ~e_l0);
    chk("R4 upper slot0", gnt_u0_o, e_u0);
    chk("R5 upper slot1", gnt_u1_o, e_u1);
    chk("R4 lower slot0", gnt_l0_o, e_l0);
    chk("R5 lower slot1", gnt_l1_o, e_l1);
    // R1 R2 R6 R8 structural checks
    checks++;
    if (!($onehot0(gnt_u0_o) && $onehot0(gnt_u1_o) && $onehot0(gnt_l0_o) && $onehot0(gnt_l1_o))) begin
      fails++;
      $display("FAIL R1: actual %h %h %h %h expected one-hot", gnt_u0_o, gnt_u1_o, gnt_l0_o, gnt_l1_o);
    end
    checks++;
    if (((gnt_u0_o & ~(u0 & hf)) | (gnt_u1_o & ~(u1 & hf)) |
         (gnt_l0_o & ~(l0 & ~hf)) | (gnt_l1_o & ~(l1 & ~hf))) != '0) begin
      fails++;
      $display("FAIL R2: actual stray grant expected none");
    end
    checks++;
    if (((gnt_u0_o & gnt_u1_o) | (gnt_l0_o & gnt_l1_o)) != '0) begin
      fails++;
      $display("FAIL R6: actual %h/%h expected disjoint", gnt_u0_o & gnt_u1_o, gnt_l0_o & gnt_l1_o);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  initial begin
    repeat (3) @(posedge clk_i);
    // R9 idle state at reset
    @(negedge clk_i);
    chk("R9 idle u0", gnt_u0_o, '0);
    chk("R9 idle l1", gnt_l1_o, '0);
    rst_ni = 1'b1;

    // R3: wrong-half requests only
    apply(20'h0_00ff, 20'h0, 20'h0, 20'h0_00ff, 20'h0_00f0);
    chk("R3 lower ignored", gnt_l0_o | gnt_l1_o, '0);
    apply(20'h0_0000, 20'hf_ffff, 20'hf_ffff, 20'h0, 20'h0);
    chk("R3 upper ignored", gnt_u0_o | gnt_u1_o, '0);

    // R5 flex entry fills the open slot: entry0 wants slot1 only, entry1 both
    apply(20'h0_0003, 20'h0_0002, 20'h0_0003, 20'h0, 20'h0);
    chk("R5 flex u0", gnt_u0_o, 20'h0_0002);
    chk("R5 flex u1", gnt_u1_o, 20'h0_0001);

    // R7 R8 four grants at once
    apply(20'h0_000c, 20'h0_000c, 20'h0_000c, 20'h0_0003, 20'h0_0003);
    checks++;
    if ($countones({gnt_u0_o, gnt_u1_o, gnt_l0_o, gnt_l1_o}) != 4) begin
      fails++;
      $display("FAIL R8: actual %0d grants expected 4",
               $countones({gnt_u0_o, gnt_u1_o, gnt_l0_o, gnt_l1_o}));
    end

    // R4 R5 exhaustive over three oldest entries (half, and 4 req lines each)
    for (int v = 0; v < (1 << 15); v++) begin
      logic [N-1:0] hf, u0, u1, l0, l1;
      hf = '0; u0 = '0; u1 = '0; l0 = '0; l1 = '0;
      for (int e = 0; e < 3; e++) begin
        hf[e] = v[5*e];
        u0[e] = v[5*e+1];
        u1[e] = v[5*e+2];
        l0[e] = v[5*e+3];
        l1[e] = v[5*e+4];
      end
      apply(hf, u0, u1, l0, l1);
    end

    // full-width pseudo-random fills at several densities
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] r [5];
      for (int j = 0; j < 5; j++) begin
        logic [31:0] a, b;
        rng = nxt(rng); a = rng;
        rng = nxt(rng); b = rng;
        r[j] = (k % 3 == 0) ? N'(a & b) : N'(a);
        if (k % 5 == 0 && j > 0) r[j] = N'(a & b & (b >> 7));
      end
      apply(r[0], r[1], r[2], r[3], r[4]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule